// File: doc/BRIEF.md
# DDR Read Latency and Strobe Generator

This block times the read side of a double-data-rate memory output. Once a read command is captured on a rising clock edge, it waits the programmed column latency and then presents a burst of data words two per clock. It also produces the bidirectional data strobe: the strobe is driven low for a one-clock preamble, toggles in step with the data, and is held low for half a clock as a postamble before it is released.

Each clock cycle is split into a rising half and a falling half. There are separate outputs for the word shown in each half, for the strobe level in each half, and for the strobe drive enable in each half. Burst data is fetched from an external source. One clock before each data cycle, the block asks for a pair of words by index, and the source answers combinationally in that same cycle. Latency (2 or 3 clocks) and burst length (2, 4 or 8 words) are captured with each command. A new read that lands while a burst is still running cuts that burst short, and the new data follows without a gap.

Top module: `ddr_rd_strobe_gen`

## Requirements
- R1: After reset, and in every cycle with no preamble, data or postamble, all enables (`dq_oe`, `dqs_oe_rise`, `dqs_oe_fall`) are 0, and `dq_rise`, `dq_fall` and `dqs_rise` are 0.
- R2: When `cl_sel`=0 (latency 2) and a read is captured at edge n, the first data cycle is the cycle that starts at edge n+1.
- R3: When `cl_sel`=1 (latency 3) and a read is captured at edge n, the first data cycle is the cycle that starts at edge n+2.
- R4: In data cycle k of a burst (k counted from 0), `dq_rise` carries word 2k and `dq_fall` carries word 2k+1. These are the `src_even` and `src_odd` values returned for `src_pair`=k.
- R5: `bl_sel` encodes the burst length as 0 for 2 words, 1 for 4 words, and 2 or 3 for 8 words. A burst has length/2 consecutive data cycles.
- R6: In every data cycle, `dq_oe`=1, both strobe enables are 1, `dqs_rise`=1 and `dqs_fall`=0, so the strobe edges line up with the data edges.
- R7: The cycle just before the first data cycle is a preamble, with both strobe enables 1, both strobe levels 0 and `dq_oe`=0. This holds unless that cycle is already a data cycle of an earlier burst.
- R8: The cycle after the last data cycle, if no preamble falls in it, is a postamble: `dqs_oe_rise`=1 with level 0, `dqs_oe_fall`=0 and `dq_oe`=0.
- R9: A read whose first data cycle would fall inside a running burst ends that burst after its current cycle. The new burst starts at word pair 0 in the next cycle, with no preamble and no idle cycle in between.
- R10: `src_req` is 1 in exactly the cycles that come right before a data cycle, and `src_pair` then gives the index of that data cycle within its burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_read | input | 1 | Read command strobe |
| cl_sel | input | 1 | Latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| bl_sel | input | 2 | Burst length select (see R5) |
| src_req | output | 1 | A word pair is needed for the next cycle |
| src_pair | output | IW | Index of the requested pair within its burst |
| src_even | input | W | Word 2k for the requested pair k |
| src_odd | input | W | Word 2k+1 for the requested pair k |
| dq_rise | output | W | Data word for the rising half of the cycle |
| dq_fall | output | W | Data word for the falling half of the cycle |
| dq_oe | output | 1 | Data output enable |
| dqs_rise | output | 1 | Strobe level in the rising half |
| dqs_fall | output | 1 | Strobe level in the falling half |
| dqs_oe_rise | output | 1 | Strobe drive enable in the rising half |
| dqs_oe_fall | output | 1 | Strobe drive enable in the falling half |

## Verification
A read captured at edge n is due to show its preamble in the cycle that starts at edge n+CL-2, its first data in the cycle at edge n+CL-1, and its postamble in the cycle after its last data. The source request for any data cycle is due one cycle earlier. The bench keeps a behavioural timeline indexed by cycle number. It writes each command's preamble and data slots into that timeline the moment the command is driven, and lets a later command overwrite the slots of an earlier one when it truncates it. It samples every output at the falling edge after each rising edge and compares it with the timeline entry for that cycle. Latency 2 and 3, all burst codes, back-to-back and overlapping reads, and a preamble that lands right after a burst ends are all covered.

// File: rtl/ddr_rd_strobe_gen.sv
module ddr_rd_strobe_gen #(
  parameter int W      = 32,
  parameter int MAX_BL = 8,
  localparam int IW    = $clog2(MAX_BL / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_read,
  input  logic          cl_sel,
  input  logic [1:0]    bl_sel,
  output logic          src_req,
  output logic [IW-1:0] src_pair,
  input  logic [W-1:0]  src_even,
  input  logic [W-1:0]  src_odd,
  output logic [W-1:0]  dq_rise,
  output logic [W-1:0]  dq_fall,
  output logic          dq_oe,
  output logic          dqs_rise,
  output logic          dqs_fall,
  output logic          dqs_oe_rise,
  output logic          dqs_oe_fall
);

  function automatic logic [IW-1:0] last_pair(input logic [1:0] code);
    case (code)
      2'd0:    last_pair = '0;
      2'd1:    last_pair = IW'(1);
      default: last_pair = IW'(MAX_BL / 2 - 1);
    endcase
  endfunction

  logic          late_q;
  logic [1:0]    late_bl_q;
  logic          pend_q;
  logic [IW-1:0] pend_last_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_q;

  wire           start    = late_q | (cmd_read & ~cl_sel);
  wire [1:0]     start_bl = late_q ? late_bl_q : bl_sel;
  wire           data_n   = pend_q | (dq_oe & (idx_q != last_q));
  wire [IW-1:0]  idx_n    = pend_q ? '0 : idx_q + 1'b1;
  wire           pre_n    = start & ~data_n;
  wire           post_n   = dq_oe & ~data_n & ~pre_n;

  assign src_req  = data_n;
  assign src_pair = idx_n;
  assign dqs_fall = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_q      <= 1'b0;
      late_bl_q   <= '0;
      pend_q      <= 1'b0;
      pend_last_q <= '0;
      idx_q       <= '0;
      last_q      <= '0;
      dq_oe       <= 1'b0;
      dq_rise     <= '0;
      dq_fall     <= '0;
      dqs_rise    <= 1'b0;
      dqs_oe_rise <= 1'b0;
      dqs_oe_fall <= 1'b0;
    end else begin
      late_q      <= cmd_read & cl_sel;
      late_bl_q   <= bl_sel;
      pend_q      <= start;
      pend_last_q <= last_pair(start_bl);
      if (data_n) idx_q <= idx_n;
      if (pend_q) last_q <= pend_last_q;
      dq_oe       <= data_n;
      dq_rise     <= data_n ? src_even : '0;
      dq_fall     <= data_n ? src_odd : '0;
      dqs_rise    <= data_n;
      dqs_oe_rise <= data_n | pre_n | post_n;
      dqs_oe_fall <= data_n | pre_n;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_oe_rise |-> (!dq_oe && !dqs_oe_fall && dq_rise == '0 && dq_fall == '0));

  assert_cl2_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_read && !cl_sel) |-> ##2 dq_oe);

  assert_cl3_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_read && cl_sel) |-> ##3 dq_oe);

  assert_preamble_before_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(dqs_oe_fall) && !$past(dqs_rise)));

  assert_postamble_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe_rise && !dqs_rise));

  assert_request_leads_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src_req |=> dq_oe);

endmodule

// File: tb/ddr_rd_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ddr_rd_strobe_gen_tb_top;
  localparam int W = 32;
  localparam int IW = 2;
  localparam int IDLE = 0, PRE = 1, DATA = 2;
  localparam int DEPTH = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_read = 1'b0;
  logic cl_sel = 1'b0;
  logic [1:0] bl_sel = 2'd0;
  logic [31:0] seed = 32'h5A00_0000;
  logic src_req;
  logic [IW-1:0] src_pair;
  logic [W-1:0] src_even, src_odd, dq_rise, dq_fall;
  logic dq_oe, dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall;

  assign src_even = seed ^ 32'({src_pair, 1'b0});
  assign src_odd  = seed ^ 32'({src_pair, 1'b1});

  always #2 clk = ~clk;

  ddr_rd_strobe_gen #(.W(W), .MAX_BL(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cl_sel(cl_sel), .bl_sel(bl_sel),
    .src_req(src_req), .src_pair(src_pair), .src_even(src_even), .src_odd(src_odd),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_rise(dqs_rise),
    .dqs_fall(dqs_fall), .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall));

  int kind [DEPTH];
  int kidx [DEPTH];
  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string tag = "R1";

  task automatic compare();
    logic [2*W+5:0] act, exp;
    logic exp_req;
    int k;
    bit post;
    k = kind[cyc];
    post = (cyc > 0) && kind[cyc-1] == DATA && k == IDLE;
    exp = '0;
    exp[2*W+5] = (k == DATA);
    exp[2*W+4] = (k == DATA);
    exp[2*W+3] = 1'b0;
    exp[2*W+2] = (k != IDLE) || post;
    exp[2*W+1] = (k != IDLE);
    exp[2*W] = 1'b0;
    if (k == DATA) begin
      exp[2*W-1:W] = seed ^ 32'(2 * kidx[cyc]);
      exp[W-1:0]   = seed ^ 32'(2 * kidx[cyc] + 1);
    end
    act = {dq_oe, dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall, 1'b0, dq_rise, dq_fall};
    exp_req = (kind[cyc+1] == DATA);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (test %s) cycle %0d: actual %h expected %h",
               k == DATA ? "R4/R6" : k == PRE ? "R7" : post ? "R8" : "R1",
               tag, cyc, act, exp);
    end else if (src_req !== exp_req || (exp_req && src_pair !== IW'(kidx[cyc+1]))) begin
      miscompares++;
      $display("FAIL R10 (test %s) cycle %0d: actual req=%b pair=%0d expected req=%b pair=%0d",
               tag, cyc, src_req, src_pair, exp_req, kidx[cyc+1]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic issue(input bit cl3, input logic [1:0] bl);
    int n, f, pairs;
    n = cyc + 1;
    f = n + (cl3 ? 2 : 1);
    pairs = (bl == 2'd0) ? 1 : (bl == 2'd1) ? 2 : 4;
    for (int c = f; c < f + 8; c++) kind[c] = IDLE;
    for (int j = 0; j < pairs; j++) begin
      kind[f+j] = DATA;
      kidx[f+j] = j;
    end
    if (kind[f-1] != DATA) kind[f-1] = PRE;
    cmd_read = 1'b1;
    cl_sel = cl3;
    bl_sel = bl;
    step();
    cmd_read = 1'b0;
    bl_sel = 2'd0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      kind[i] = IDLE;
      kidx[i] = 0;
    end
    tag = "R1";
    @(negedge clk);
    compare();
    idle(3);
    rst_n = 1'b1;
    idle(4);

    tag = "R2";
    issue(1'b0, 2'd1); idle(8);
    tag = "R3";
    issue(1'b1, 2'd1); idle(8);

    tag = "R5";
    issue(1'b0, 2'd0); idle(6);
    issue(1'b0, 2'd2); idle(8);
    seed = 32'hC3A5_0F00;
    issue(1'b1, 2'd2); idle(9);
    issue(1'b1, 2'd3); idle(9);
    issue(1'b1, 2'd0); idle(6);

    tag = "R9";
    issue(1'b0, 2'd2); idle(1); issue(1'b0, 2'd1); idle(8);
    issue(1'b1, 2'd2); issue(1'b1, 2'd0); idle(8);
    for (int i = 0; i < 5; i++) issue(1'b1, 2'd0);
    idle(6);
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 2'd1);
      step();
    end
    idle(6);

    tag = "R7";
    issue(1'b0, 2'd0); idle(1); issue(1'b0, 2'd0); idle(6);
    issue(1'b1, 2'd1); idle(2); issue(1'b1, 2'd1); idle(8);

    tag = "R9";
    for (int g = 0; g < 40; g++) begin
      bit cl3;
      cl3 = g[0];
      for (int i = 0; i < 10; i++) begin
        int r;
        r = (g * 37 + i * 11 + i * i) % 7;
        issue(cl3, 2'(r % 4));
        idle(r % 5);
      end
      idle(10);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule